// File: doc/BRIEF.md
# Programmable XOR Swizzle Address Translator

This block maps a tile coordinate to a shared-memory word offset, and an offset back to its coordinate. The tile has 16 rows and 32 columns of 4-byte words. Its memory has 32 banks, one word wide. A coordinate is a 4-bit row and a 5-bit column. The offset is 9 bits wide. The upper 4 bits are the segment, which is one full 128-byte stripe across every bank, and the segment equals the row. The lower 5 bits are the bank, which equals the column XORed with a per-row mask.

The mask is a linear function of the row over GF(2). Each row bit j has a 5-bit toggle word. The mask is the XOR of the toggle words of all row bits that are set. Software writes one toggle word at a time through a small configuration port, so any of the 2^20 toggle settings can be loaded. When every toggle is clear, the layout is plain row-major. Setting toggle word j to `1<<j` gives column XOR row. Setting it to `1<<(j+1)` gives column XOR twice the row. The swizzle moves words only within a row, so every row still covers all 32 banks.

Each direction is translated in one registered stage. The forward path turns a coordinate into an offset. The inverse path turns an offset into a coordinate. A path's outputs change only on a cycle when its request is valid.

Top module: `xor_swizzle_addr`

## Requirements
- R1: While reset is held, and after it is released, every toggle word is zero. Both valid outputs are 0 and all offset and coordinate outputs are 0.
- R2: When `fwd_valid` is high at a clock edge, the outputs take new values at that edge. `fwd_out_valid` goes to 1. `fwd_offset[8:5]` equals the row. `fwd_offset[4:0]` equals the column XOR mask(row).
- R3: mask(r) is the XOR of toggle word j over every j where bit j of r is 1. A write with `cfg_we`=1 loads `cfg_data` into toggle word `cfg_sel`. Bit i of the word is the toggle from row bit j to column bit i.
- R4: While all toggle words are zero, the forward bank bits equal the column.
- R5: A translation presented in the same cycle as a configuration write uses the old toggle words. A translation presented in the next cycle uses the new ones.
- R6: When `inv_valid` is high at a clock edge, the outputs take new values at that edge. `inv_out_valid` goes to 1. `inv_row` equals `inv_offset[8:5]`. `inv_col` equals `inv_offset[4:0]` XOR mask(`inv_offset[8:5]`).
- R7: For a fixed row and any toggle setting, the 32 columns map to 32 distinct bank values.
- R8: Feeding a forward offset into the inverse path returns the original row and column, as long as the toggles are unchanged.
- R9: In a cycle where a path's valid input is low, its valid output goes to 0 and its data outputs keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Toggle word write strobe |
| cfg_sel | input | 2 | Row bit whose toggle word is written |
| cfg_data | input | 5 | New toggle word, bit i drives column bit i |
| fwd_valid | input | 1 | Forward request valid |
| fwd_row | input | 4 | Forward request row |
| fwd_col | input | 5 | Forward request column |
| fwd_out_valid | output | 1 | Forward result valid |
| fwd_offset | output | 9 | Segment (8:5) and bank (4:0) |
| inv_valid | input | 1 | Inverse request valid |
| inv_offset | input | 9 | Offset to translate back |
| inv_out_valid | output | 1 | Inverse result valid |
| inv_row | output | 4 | Recovered row |
| inv_col | output | 5 | Recovered column |

## Verification
The hardest case to reach from the ports is a configuration write in the same cycle as a translation that depends on the toggle word being written. In that case the old word must apply, and the new word must apply one cycle later. The stimulus produces this by asserting the strobe together with forward and inverse requests whose row has the written bit set. It then repeats the same request on the next cycle. Round trips and per-row bank sweeps are run under several toggle settings, including pseudo-random ones, so the inverse and permutation properties do not depend on one chosen matrix.

// File: rtl/xor_swizzle_addr.sv
module xor_swizzle_addr #(
  parameter int ROW_BITS = 4,
  parameter int COL_BITS = 5,
  localparam int SEL_W = $clog2(ROW_BITS),
  localparam int OFF_W = ROW_BITS + COL_BITS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [SEL_W-1:0]    cfg_sel,
  input  logic [COL_BITS-1:0] cfg_data,
  input  logic                fwd_valid,
  input  logic [ROW_BITS-1:0] fwd_row,
  input  logic [COL_BITS-1:0] fwd_col,
  output logic                fwd_out_valid,
  output logic [OFF_W-1:0]    fwd_offset,
  input  logic                inv_valid,
  input  logic [OFF_W-1:0]    inv_offset,
  output logic                inv_out_valid,
  output logic [ROW_BITS-1:0] inv_row,
  output logic [COL_BITS-1:0] inv_col
);

  logic [ROW_BITS-1:0][COL_BITS-1:0] tog;

  function automatic logic [COL_BITS-1:0] mask_of(
    input logic [ROW_BITS-1:0] r,
    input logic [ROW_BITS-1:0][COL_BITS-1:0] t
  );
    logic [COL_BITS-1:0] m;
    m = '0;
    for (int j = 0; j < ROW_BITS; j++)
      if (r[j]) m = m ^ t[j];
    return m;
  endfunction

  logic [ROW_BITS-1:0] inv_seg;
  logic [COL_BITS-1:0] fwd_bank, inv_bank;

  assign inv_seg  = inv_offset[OFF_W-1:COL_BITS];
  assign fwd_bank = fwd_col ^ mask_of(fwd_row, tog);
  assign inv_bank = inv_offset[COL_BITS-1:0] ^ mask_of(inv_seg, tog);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tog           <= '0;
      fwd_out_valid <= 1'b0;
      fwd_offset    <= '0;
      inv_out_valid <= 1'b0;
      inv_row       <= '0;
      inv_col       <= '0;
    end else begin
      if (cfg_we) tog[cfg_sel] <= cfg_data;
      fwd_out_valid <= fwd_valid;
      if (fwd_valid) fwd_offset <= {fwd_row, fwd_bank};
      inv_out_valid <= inv_valid;
      if (inv_valid) begin
        inv_row <= inv_seg;
        inv_col <= inv_bank;
      end
    end
  end

  a_r2_seg_is_row: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid |=> fwd_out_valid && fwd_offset[OFF_W-1:COL_BITS] == $past(fwd_row));

  a_r4_clear_is_rowmajor: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_valid && tog == '0) |=> fwd_offset[COL_BITS-1:0] == $past(fwd_col));

  a_r5_cfg_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> tog[$past(cfg_sel)] == $past(cfg_data));

  a_r6_inv_row: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid |=> inv_out_valid && inv_row == $past(inv_seg));

  a_r9_fwd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !fwd_valid |=> !fwd_out_valid && $stable(fwd_offset));

  a_r9_inv_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !inv_valid |=> !inv_out_valid && $stable(inv_row) && $stable(inv_col));

endmodule

// File: tb/xor_swizzle_addr_tb.sv
`timescale 1ns/1ps
module xor_swizzle_addr_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 0; logic [1:0] cfg_sel = 0; logic [4:0] cfg_data = 0;
  logic fwd_valid = 0; logic [3:0] fwd_row = 0; logic [4:0] fwd_col = 0;
  logic fwd_out_valid; logic [8:0] fwd_offset;
  logic inv_valid = 0; logic [8:0] inv_offset = 0;
  logic inv_out_valid; logic [3:0] inv_row; logic [4:0] inv_col;

  always #2.5 clk = ~clk;

  xor_swizzle_addr u_dut (.clk, .rst_n, .cfg_we, .cfg_sel, .cfg_data,
    .fwd_valid, .fwd_row, .fwd_col, .fwd_out_valid, .fwd_offset,
    .inv_valid, .inv_offset, .inv_out_valid, .inv_row, .inv_col);

  int n_run = 0, n_fail = 0;
  int ref_tog [4];
  int e_fv = 0, e_fo = 0, e_iv = 0, e_ir = 0, e_ic = 0;

  function automatic int rmask(int r);
    int m = 0;
    for (int j = 0; j < 4; j++) if ((r >> j) & 1) m = m ^ ref_tog[j];
    return m;
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag, bit fv, int fr, int fc, bit iv, int io,
                      bit cw, int cs, int cd);
    fwd_valid = fv; fwd_row = 4'(fr); fwd_col = 5'(fc);
    inv_valid = iv; inv_offset = 9'(io);
    cfg_we = cw; cfg_sel = 2'(cs); cfg_data = 5'(cd);
    e_fv = fv; e_iv = iv;
    if (fv) e_fo = (fr << 5) | (fc ^ rmask(fr));
    if (iv) begin e_ir = io >> 5; e_ic = (io & 31) ^ rmask(io >> 5); end
    if (cw) ref_tog[cs] = cd;
    @(negedge clk);
    chk(tag, "fwd_out_valid", int'(fwd_out_valid), e_fv);
    chk(tag, "fwd_offset", int'(fwd_offset), e_fo);
    chk(tag, "inv_out_valid", int'(inv_out_valid), e_iv);
    chk(tag, "inv_row", int'(inv_row), e_ir);
    chk(tag, "inv_col", int'(inv_col), e_ic);
  endtask

  task automatic load_all(int t0, int t1, int t2, int t3);
    step("R3", 0, 0, 0, 0, 0, 1, 0, t0);
    step("R3", 0, 0, 0, 0, 0, 1, 1, t1);
    step("R3", 0, 0, 0, 0, 0, 1, 2, t2);
    step("R3", 0, 0, 0, 0, 0, 1, 3, t3);
  endtask

  task automatic sweep_row(int r);
    bit [31:0] seen = '0;
    for (int c = 0; c < 32; c++) begin
      step("R7", 1, r, c, 0, 0, 0, 0, 0);
      seen[fwd_offset[4:0]] = 1'b1;
    end
    chk("R7", "distinct banks", $countones(seen), 32);
  endtask

  task automatic round_trip(int r, int c);
    int o;
    step("R2", 1, r, c, 0, 0, 0, 0, 0);
    o = int'(fwd_offset);
    step("R6", 0, 0, 0, 1, o, 0, 0, 0);
    chk("R8", "round-trip row", int'(inv_row), r);
    chk("R8", "round-trip col", int'(inv_col), c);
  endtask

  initial begin
    #(5.0 * 20000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    for (int j = 0; j < 4; j++) ref_tog[j] = 0;
    fwd_valid = 1; inv_valid = 1; cfg_we = 1; cfg_data = 5'h1f;
    repeat (3) @(negedge clk);
    chk("R1", "fwd_out_valid in reset", int'(fwd_out_valid), 0);
    chk("R1", "inv_out_valid in reset", int'(inv_out_valid), 0);
    fwd_valid = 0; inv_valid = 0; cfg_we = 0;
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "fwd_offset after reset", int'(fwd_offset), 0);
    chk("R1", "inv_row after reset", int'(inv_row), 0);
    chk("R1", "inv_col after reset", int'(inv_col), 0);

    for (int k = 0; k < 16; k++) begin
      step("R4", 1, k, (k * 7 + 3) & 31, 0, 0, 0, 0, 0);
      chk("R4", "bank equals column", int'(fwd_offset[4:0]), (k * 7 + 3) & 31);
    end
    step("R4", 1, 15, 31, 1, (15 << 5) | 9, 0, 0, 0);

    step("R5", 1, 2, 5, 1, (2 << 5) | 5, 1, 1, 5'h02);
    step("R5", 1, 2, 5, 1, (2 << 5) | 5, 0, 0, 0);
    chk("R5", "new toggle used", int'(fwd_offset[4:0]), 5 ^ 2);
    load_all(1, 2, 4, 8);
    step("R5", 1, 13, 0, 0, 0, 1, 2, 5'h10);
    chk("R5", "old toggle used", int'(fwd_offset[4:0]), 13);
    step("R5", 1, 13, 0, 0, 0, 0, 0, 0);
    chk("R5", "new toggle used", int'(fwd_offset[4:0]), 1 ^ 8 ^ 16);

    load_all(1, 2, 4, 8);
    sweep_row(11);
    round_trip(11, 17);
    load_all(2, 4, 8, 16);
    sweep_row(5);
    sweep_row(15);
    round_trip(7, 0);
    round_trip(15, 31);

    for (int k = 0; k < 6; k++) begin
      load_all($urandom & 31, $urandom & 31, $urandom & 31, $urandom & 31);
      sweep_row($urandom & 15);
      for (int t = 0; t < 20; t++)
        step("R2", 1, $urandom & 15, $urandom & 31, 1, $urandom & 511, 0, 0, 0);
      for (int t = 0; t < 4; t++) round_trip($urandom & 15, $urandom & 31);
    end

    step("R6", 1, 9, 9, 1, 300, 0, 0, 0);
    step("R9", 0, 3, 3, 0, 17, 0, 0, 0);
    step("R9", 0, 4, 8, 0, 99, 1, 0, 5'h0a);
    step("R9", 1, 4, 8, 0, 99, 0, 0, 0);
    step("R9", 0, 0, 0, 1, 99, 0, 0, 0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule